// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block controls a port of up to eight general-purpose pins. Each pin has its own set of registers, reached over a simple synchronous register bus. The bus has a byte address, a write strobe, write data and registered read data. Software can enable each pin and make it an input or an output. It can also release the output driver, set the drive value, and read back the pin level after synchronisation.

Each pin carries a trigger detector. The detector fires on a level, on one chosen edge, or on both edges. It works on a version of the pin input that has passed a synchroniser and a debounce filter with a programmable threshold. A detected event sets a sticky pending bit. Software clears that bit by writing one to a per-pin clear register. The pending bits of all pins are also collected into one port status word. A single port interrupt line is raised while any pending pin has its interrupt enabled.

Top module: `gpio_irq_port`

## Requirements
- R1: Pin n owns a 32-byte register window starting at byte address n*0x20. Its control word sits at window offset 0x00 and reads back what was written. The control word fields are: bit 0 pin on, bit 1 drive direction (1 = output), bits 3:2 trigger mode, bit 4 trigger sense, bit 6 interrupt enable. A write to one window leaves every other window unchanged.
- R2: After reset, all control words, thresholds and drive values are 0. The release bit (offset 0x0C, bit 0) of every pin is 1. `pad_oe` is all 0 and `irq` is 0.
- R3: `pad_oe[n]` is 1 exactly when pin n is on, its direction is output, and its release bit is 0. `pad_out[n]` follows bit 0 of the drive register at offset 0x10.
- R4: Bit 0 of the level register at offset 0x08 shows `pad_in[n]` after a two-flop synchroniser. Writes to this register have no effect.
- R5: The filtered input takes a new synchronised value only after that value has differed from it on threshold+1 consecutive clocks. The threshold is held in bits 7:0 at offset 0x04. A threshold of 0 lets the filtered input follow one clock behind.
- R6: A pin sets its pending bit only when it is on and its trigger mode is not 0 (0 = off). An off pin or mode 0 never raises a pending bit.
- R7: In mode 2 (one edge), sense 1 fires on a rising edge of the filtered input and sense 0 fires on a falling edge. An edge is a difference from the previous clock's filtered value.
- R8: In mode 3 (both edges), either edge fires, whatever the sense bit holds.
- R9: In mode 1 (level), sense 1 means active-high and sense 0 means active-low. The pending bit stays set, and sets again in the same clock as a clear, while the active level remains.
- R10: Writing a word with bit 0 = 1 to offset 0x14 clears that pin's pending bit. Writing bit 0 = 0 there leaves it unchanged. A detection in the same clock as a clear wins.
- R11: The status word at byte address 0x104 holds pin n's pending bit in bit n.
- R12: `irq` is 1 exactly when some pin has both its pending bit and its interrupt-enable bit set.
- R13: Read data appears on `bus_rdata` one clock after the address is presented. Addresses outside the pin windows and the status word read as 0, and so does the clear register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pin levels from the pads |
| pad_out | output | NUM_PINS | Drive values toward the pads |
| pad_oe | output | NUM_PINS | Driver enables toward the pads |
| irq | output | 1 | Port interrupt line |

## Verification
The assertions assume a few things about the inputs. Bus inputs are stable around each rising edge. `pad_in` may change at any clock. Reads and writes are single-cycle, so read timing is judged against the address of the previous clock. The stimulus drives every input on the falling edge. It holds `pad_in` and the bus idle during reset, and it keeps pad pulses either well shorter or well longer than the programmed debounce window, so both outcomes of the filter are reached.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_W       = 32;
  localparam int WIN_BYTES   = 32;
  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_THRESH  = 'h04;
  localparam int OFS_LEVEL   = 'h08;
  localparam int OFS_RELEASE = 'h0C;
  localparam int OFS_DRIVE   = 'h10;
  localparam int OFS_CLEAR   = 'h14;
  localparam int STATUS_ADDR = 'h104;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_LEVEL = 2'd1,
    MODE_EDGE  = 2'd2,
    MODE_BOTH  = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic       int_en;
    logic       sense;
    trig_mode_e mode;
    logic       dir_out;
    logic       on;
  } pin_ctrl_t;

  function automatic logic [REG_W-1:0] ctrl_pack(pin_ctrl_t c);
    return {{(REG_W-7){1'b0}}, c.int_en, 1'b0, c.sense, c.mode, c.dir_out, c.on};
  endfunction

  function automatic pin_ctrl_t ctrl_unpack(logic [REG_W-1:0] w);
    pin_ctrl_t c;
    c.on      = w[0];
    c.dir_out = w[1];
    c.mode    = trig_mode_e'(w[3:2]);
    c.sense   = w[4];
    c.int_en  = w[6];
    return c;
  endfunction

  // Event test on the filtered input: cur is this clock, prev the last one.
  function automatic logic trig_fire(pin_ctrl_t c, logic cur, logic prev);
    logic f;
    f = 1'b0;
    if (c.on) begin
      unique case (c.mode)
        MODE_LEVEL: f = (cur == c.sense);
        MODE_EDGE:  f = c.sense ? (cur & ~prev) : (~cur & prev);
        MODE_BOTH:  f = cur ^ prev;
        default:    f = 1'b0;
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int THR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad,
  input  logic [THR_W-1:0] thresh,
  output logic             sync_o,
  output logic             filt_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic [THR_W-1:0]       run_q;
  logic                   filt_q;
  logic                   differs;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], pad};
  end

  assign sync_o  = chain_q[SYNC_STAGES-1];
  assign differs = sync_o != filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (differs) begin
      if (run_q == thresh) begin
        filt_q <= sync_o;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_ctrl_t ctrl,
  input  logic      filt,
  input  logic      clear,
  output logic      fire_o,
  output logic      pend_o
);
  logic prev_q;
  logic pend_q;

  assign fire_o = trig_fire(ctrl, filt, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= filt;
      pend_q <= (pend_q & ~clear) | fire_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 9,
  parameter int THR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  localparam int OFS_W = $clog2(WIN_BYTES);
  localparam int WIN_W = ADDR_W - OFS_W;
  localparam int IDX_W = WIN_W - 1;

  logic [OFS_W-1:0] ofs;
  logic [WIN_W-1:0] win;
  logic [IDX_W-1:0] idx;

  logic [NUM_PINS-1:0] pend_vec, fire_vec, clr_vec, sync_vec, filt_vec;
  logic [NUM_PINS-1:0] ie_vec, armed_vec;
  logic [NUM_PINS-1:0][REG_W-1:0] pin_rd_w;
  logic [REG_W-1:0] rd_next;

  assign ofs = bus_addr[OFS_W-1:0];
  assign win = bus_addr[ADDR_W-1:OFS_W];
  assign idx = bus_addr[ADDR_W-2:OFS_W];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_ctrl_t        ctrl_q;
    logic [THR_W-1:0] thr_q;
    logic             rel_q;
    logic             drv_q;
    logic             sel;

    assign sel = bus_we && (win == WIN_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        thr_q  <= '0;
        rel_q  <= 1'b1;
        drv_q  <= 1'b0;
      end else if (sel) begin
        if (ofs == OFS_W'(OFS_CTRL))    ctrl_q <= ctrl_unpack(bus_wdata);
        if (ofs == OFS_W'(OFS_THRESH))  thr_q  <= bus_wdata[THR_W-1:0];
        if (ofs == OFS_W'(OFS_RELEASE)) rel_q  <= bus_wdata[0];
        if (ofs == OFS_W'(OFS_DRIVE))   drv_q  <= bus_wdata[0];
      end
    end

    assign clr_vec[i] = sel && (ofs == OFS_W'(OFS_CLEAR)) && bus_wdata[0];

    gpio_in_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .THR_W      (THR_W)
    ) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .pad   (pad_in[i]),
      .thresh(thr_q),
      .sync_o(sync_vec[i]),
      .filt_o(filt_vec[i])
    );

    gpio_pin_event u_event (
      .clk   (clk),
      .rst_n (rst_n),
      .ctrl  (ctrl_q),
      .filt  (filt_vec[i]),
      .clear (clr_vec[i]),
      .fire_o(fire_vec[i]),
      .pend_o(pend_vec[i])
    );

    assign ie_vec[i]    = ctrl_q.int_en;
    assign armed_vec[i] = ctrl_q.on && (ctrl_q.mode != MODE_OFF);
    assign pad_oe[i]    = ctrl_q.on && ctrl_q.dir_out && !rel_q;
    assign pad_out[i]   = drv_q;

    always_comb begin
      pin_rd_w[i] = '0;
      unique case (ofs)
        OFS_W'(OFS_CTRL):    pin_rd_w[i] = ctrl_pack(ctrl_q);
        OFS_W'(OFS_THRESH):  pin_rd_w[i] = REG_W'(thr_q);
        OFS_W'(OFS_LEVEL):   pin_rd_w[i] = REG_W'(sync_vec[i]);
        OFS_W'(OFS_RELEASE): pin_rd_w[i] = REG_W'(rel_q);
        OFS_W'(OFS_DRIVE):   pin_rd_w[i] = REG_W'(drv_q);
        default:             pin_rd_w[i] = '0;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(STATUS_ADDR))
      rd_next = REG_W'(pend_vec);
    else if (!bus_addr[ADDR_W-1] && (int'(idx) < NUM_PINS))
      rd_next = pin_rd_w[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  assign irq = |(pend_vec & ie_vec);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] fire_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] sync_vec,
  input logic [NUM_PINS-1:0] filt_vec,
  input logic [NUM_PINS-1:0] armed_vec
);
  logic unmapped;
  assign unmapped = bus_addr[ADDR_W-1] && (bus_addr != ADDR_W'('h104));

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unmapped) |-> (bus_rdata == 32'd0)); // R13

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_vec != '0)); // R12

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_DRIVER_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pad_oe[i]) |-> $past(bus_we)); // R3

    AST_FILTER_MOVES_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_vec[i]) |-> $past(sync_vec[i] != filt_vec[i])); // R5

    AST_FIRE_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      fire_vec[i] |-> armed_vec[i]); // R6

    AST_PEND_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_vec[i]) |-> $past(fire_vec[i])); // R7

    AST_CLEAR_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !fire_vec[i]) |=> !pend_vec[i]); // R10
  end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_rdata(bus_rdata),
  .pad_oe   (pad_oe),
  .irq      (irq),
  .pend_vec (pend_vec),
  .fire_vec (fire_vec),
  .clr_vec  (clr_vec),
  .sync_vec (sync_vec),
  .filt_vec (filt_vec),
  .armed_vec(armed_vec)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  localparam int NP = 8;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R2";

  always #2 clk = ~clk;

  gpio_irq_port #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit m_on[NP], m_dir[NP], m_sense[NP], m_ie[NP], m_rel[NP], m_drv[NP];
  int m_mode[NP], m_thr[NP], m_cnt[NP];
  bit m_s1[NP], m_s2[NP], m_f[NP], m_fp[NP], m_pend[NP];
  int m_rd;

  function automatic int model_read(int a);
    int p, o, r;
    r = 0;
    if (a == 'h104) begin
      for (int k = 0; k < NP; k++) if (m_pend[k]) r += (1 << k);
    end else if (a < 'h100) begin
      p = a / 32;
      o = a % 32;
      if (p < NP) begin
        if (o == 0)  r = m_ie[p]*64 + m_sense[p]*16 + m_mode[p]*4 + m_dir[p]*2 + m_on[p];
        if (o == 4)  r = m_thr[p];
        if (o == 8)  r = m_s2[p];
        if (o == 12) r = m_rel[p];
        if (o == 16) r = m_drv[p];
      end
    end
    return r;
  endfunction

  function automatic bit model_fire(int p);
    if (!m_on[p]) return 0;
    case (m_mode[p])
      1: return m_f[p] == m_sense[p];
      2: return m_sense[p] ? (m_f[p] && !m_fp[p]) : (!m_f[p] && m_fp[p]);
      3: return m_f[p] != m_fp[p];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int rd_n;
    cycles++;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_on[p] = 0; m_dir[p] = 0; m_sense[p] = 0; m_ie[p] = 0; m_rel[p] = 1;
        m_drv[p] = 0; m_mode[p] = 0; m_thr[p] = 0; m_cnt[p] = 0;
        m_s1[p] = 0; m_s2[p] = 0; m_f[p] = 0; m_fp[p] = 0; m_pend[p] = 0;
      end
      m_rd = 0;
    end else begin
      rd_n = model_read(int'(bus_addr));
      for (int p = 0; p < NP; p++) begin
        bit clr, fire;
        clr  = bus_we && (int'(bus_addr) == p*32 + 20) && bus_wdata[0];
        fire = model_fire(p);
        m_pend[p] = (m_pend[p] && !clr) || fire;
        m_fp[p] = m_f[p];
        if (m_s2[p] != m_f[p]) begin
          if (m_cnt[p] >= m_thr[p]) begin m_f[p] = m_s2[p]; m_cnt[p] = 0; end
          else m_cnt[p]++;
        end else m_cnt[p] = 0;
        m_s2[p] = m_s1[p];
        m_s1[p] = pad_in[p];
      end
      if (bus_we && bus_addr < 'h100 && int'(bus_addr)/32 < NP) begin
        int p, o;
        p = int'(bus_addr) / 32;
        o = int'(bus_addr) % 32;
        if (o == 0) begin
          m_on[p] = bus_wdata[0]; m_dir[p] = bus_wdata[1]; m_mode[p] = int'(bus_wdata[3:2]);
          m_sense[p] = bus_wdata[4]; m_ie[p] = bus_wdata[6];
        end
        if (o == 4)  m_thr[p] = int'(bus_wdata[7:0]);
        if (o == 12) m_rel[p] = bus_wdata[0];
        if (o == 16) m_drv[p] = bus_wdata[0];
      end
      m_rd = rd_n;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NP-1:0] e_oe, e_out;
      bit e_irq;
      e_irq = 0;
      for (int p = 0; p < NP; p++) begin
        e_oe[p]  = m_on[p] && m_dir[p] && !m_rel[p];
        e_out[p] = m_drv[p];
        if (m_pend[p] && m_ie[p]) e_irq = 1;
      end
      chk({cur_req, " R3 pad_oe"}, 32'(pad_oe), 32'(e_oe));
      chk({cur_req, " R3 pad_out"}, 32'(pad_out), 32'(e_out));
      chk({cur_req, " R12 irq"}, 32'(irq), 32'(e_irq));
      chk({cur_req, " R13 rdata"}, bus_rdata, 32'(m_rd));
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(input int a, input int d);
    bus_addr = AW'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] mask, input logic [31:0] exp, input string req);
    bus_addr = AW'(a);
    @(negedge clk);
    chk(req, bus_rdata & mask, exp);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R2";
    chk("R2 irq after reset", 32'(irq), 0);
    chk("R2 pad_oe after reset", 32'(pad_oe), 0);
    rd('h0C, 32'hFFFF_FFFF, 1, "R2 release bit resets to 1");
    rd('hE0, 32'hFFFF_FFFF, 0, "R2 control resets to 0");

    cur_req = "R1";
    wr('h60, 'h5F);
    rd('h60, 32'hFFFF_FFFF, 'h5F, "R1 pin3 control readback");
    rd('h40, 32'hFFFF_FFFF, 0, "R1 pin2 window untouched");
    wr('h60, 0);

    cur_req = "R3";
    wr('h30, 1); wr('h20, 3); wr('h2C, 0);
    idle(1);
    chk("R3 pin1 driver on", 32'(pad_oe[1]), 1);
    chk("R3 pin1 drive value", 32'(pad_out[1]), 1);
    wr('h2C, 1);
    chk("R3 pin1 released", 32'(pad_oe[1]), 0);

    cur_req = "R4";
    pad_in[4] = 1'b1;
    idle(3);
    rd('h88, 32'hFFFF_FFFF, 1, "R4 synchronised level");
    wr('h88, 0);
    rd('h88, 32'hFFFF_FFFF, 1, "R4 level register ignores writes");
    pad_in[4] = 1'b0;

    cur_req = "R5";
    wr('hA4, 3); wr('hA0, 'h55);
    pad_in[5] = 1'b1; idle(2); pad_in[5] = 1'b0;
    idle(8);
    chk("R5 short pulse filtered out", 32'(irq), 0);

    cur_req = "R7";
    wr('h00, 'h59);
    pad_in[0] = 1'b1; idle(6);
    chk("R7 rising edge fires", 32'(irq), 1);
    rd('h104, 32'h1, 1, "R11 status bit0");
    wr('h14, 1);
    chk("R10 clear drops irq", 32'(irq), 0);
    pad_in[0] = 1'b0; idle(6);
    chk("R7 falling ignored in rising sense", 32'(irq), 0);
    wr('h00, 'h49);
    pad_in[0] = 1'b1; idle(6);
    chk("R7 rising ignored in falling sense", 32'(irq), 0);
    pad_in[0] = 1'b0; idle(6);
    chk("R7 falling edge fires", 32'(irq), 1);
    wr('h14, 1);

    cur_req = "R8";
    wr('h40, 'h4D);
    pad_in[2] = 1'b1; idle(6);
    chk("R8 rise fires with sense 0", 32'(irq), 1);
    wr('h54, 1);
    pad_in[2] = 1'b0; idle(6);
    chk("R8 fall fires", 32'(irq), 1);
    rd('h104, 32'hFF, 'h04, "R11 status bit2 only");
    wr('h54, 1);

    cur_req = "R10";
    pad_in[2] = 1'b1; idle(6);
    wr('h54, 0); idle(1);
    chk("R10 write of 0 keeps pending", 32'(irq), 1);
    wr('h54, 1);
    chk("R10 write of 1 clears", 32'(irq), 0);

    cur_req = "R12";
    wr('h40, 'h0D);
    pad_in[2] = 1'b0; idle(6);
    chk("R12 masked pin keeps irq low", 32'(irq), 0);
    rd('h104, 32'h4, 'h4, "R12 masked pin still pending");
    wr('h54, 1);

    cur_req = "R9";
    pad_in[5] = 1'b1; idle(12);
    chk("R5 long level passes filter", 32'(irq), 1);
    wr('hB4, 1); idle(1);
    chk("R9 level re-asserts after clear", 32'(irq), 1);
    pad_in[5] = 1'b0; idle(12);
    wr('hB4, 1);
    chk("R9 inactive level clears", 32'(irq), 0);

    cur_req = "R6";
    wr('hC0, 'h41); wr('hE0, 'h58);
    pad_in[6] = 1'b1; pad_in[7] = 1'b1; idle(6);
    pad_in[6] = 1'b0; pad_in[7] = 1'b0; idle(6);
    rd('h104, 32'hC0, 0, "R6 mode-0 and off pins never pend");

    cur_req = "R13";
    rd('h1F0, 32'hFFFF_FFFF, 0, "R13 unmapped address");
    rd('h100, 32'hFFFF_FFFF, 0, "R13 unused status slot");
    rd('h14, 32'hFFFF_FFFF, 0, "R13 clear register reads 0");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles == 20000 && !done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog %s actual=running expected=finished", cur_req);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule